// File: doc/BRIEF.md
# One-Hot Sequencer for a Shift-and-Add Multiplier

This block sequences a serial shift-and-add multiplier. It has three state flip-flops and exactly one of them is set at any time. The waiting state holds until a start request arrives. The block then alternates between an add phase and a shift phase. In the add phase it asks the datapath to add the multiplicand to the partial product when the current multiplier bit is 1. In the shift phase it asks for the right shift and the counter decrement. The block returns to waiting once the bit counter reports zero during a shift phase. The datapath registers and the bit counter sit outside this block; the block only produces their control strobes.

The next-state logic is built structurally from the flow chart. Each state is a D flip-flop. Each two-way decision is a 1-to-2 demultiplexer, with the state signal on its enable and the tested input on its select. Each point where paths merge is an OR gate. Each conditional strobe is a gated exit of its state. Every control output and every state line behaves cycle for cycle like a two-bit encoded sequencer followed by a decoder. The state lines are brought out so that the datapath, or a checker, can use them directly.

The interface is control only: plain level pins with no valid/ready flow. The start request is sampled only in the waiting state, so no back-pressure applies.

Top module: `shiftadd_onehot_ctl`

## Requirements
- R1: While `rst_n` is low, the waiting state line is 1 and the add and shift state lines are 0. Reset is asynchronous and active low. With `go_i` low, all four control strobes are then 0.
- R2: Exactly one of `st_idle_o`, `st_add_o` and `st_shift_o` is 1 in every cycle.
- R3: From the waiting state, the next state is the add state when `go_i` is 1 at the clock edge. Otherwise the block stays in the waiting state.
- R4: The add state is always followed by the shift state, whatever the inputs are.
- R5: From the shift state, the next state is the waiting state when `cnt_zero_i` is 1. Otherwise it is the add state.
- R6: `init_o` is 1 in the same cycle exactly when the block is in the waiting state and `go_i` is 1.
- R7: `add_en_o` is 1 exactly when the block is in the add state and `mplier_lsb_i` is 1.
- R8: `carry_clr_o` is 1 exactly when `init_o` would be 1, or when the block is in the shift state.
- R9: `shift_o` is 1 exactly when the block is in the shift state.
- R10: Outside the waiting state, `go_i` has no effect. Outside the shift state, `cnt_zero_i` has no effect. `mplier_lsb_i` never affects the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start request, sampled in the waiting state |
| cnt_zero_i | input | 1 | Bit counter has reached zero |
| mplier_lsb_i | input | 1 | Current low bit of the multiplier register |
| init_o | output | 1 | Clear the accumulator and preset the bit counter |
| add_en_o | output | 1 | Load the adder result into the accumulator |
| carry_clr_o | output | 1 | Clear the carry flip-flop |
| shift_o | output | 1 | Shift the product right and decrement the counter |
| st_idle_o | output | 1 | Waiting state line |
| st_add_o | output | 1 | Add state line |
| st_shift_o | output | 1 | Shift state line |

## Verification
A wrong state flip-flop value shows at the ports in the same cycle it occurs, because the three state lines are outputs. A lost or duplicated one-hot bit appears as zero or two state lines high. A wrong transition shows one clock edge after the input that caused it. At that point the control strobes also diverge from an encoded two-bit reference. `add_en_o` and `carry_clr_o` show the error at once, and `init_o` shows it as soon as `go_i` is raised. Random input sequences therefore expose a faulty demultiplexer select or a missing junction path within a few cycles of first reaching that path.

// File: rtl/shiftadd_ctl_pkg.sv
package shiftadd_ctl_pkg;
  localparam int NUM_STATES = 3;

  typedef enum int {
    ST_IDLE  = 0,
    ST_ADD   = 1,
    ST_SHIFT = 2
  } st_idx_e;

  typedef struct packed {
    logic init;
    logic add_en;
    logic carry_clr;
    logic shift;
  } ctl_t;
endpackage

// File: rtl/ohc_state_ff.sv
module ohc_state_ff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= d;
  end
endmodule

// File: rtl/ohc_demux2.sv
module ohc_demux2 (
  input  logic       en,
  input  logic       sel,
  output logic [1:0] exits
);
  always_comb begin
    exits[0] = en & ~sel;
    exits[1] = en &  sel;
  end
endmodule

// File: rtl/ohc_join.sv
module ohc_join #(
  parameter int N = 2
) (
  input  logic [N-1:0] paths,
  output logic         merged
);
  assign merged = |paths;
endmodule

// File: rtl/shiftadd_onehot_ctl.sv
module shiftadd_onehot_ctl
  import shiftadd_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic cnt_zero_i,
  input  logic mplier_lsb_i,
  output logic init_o,
  output logic add_en_o,
  output logic carry_clr_o,
  output logic shift_o,
  output logic st_idle_o,
  output logic st_add_o,
  output logic st_shift_o
);
  localparam int IDX_IDLE  = int'(ST_IDLE);
  localparam int IDX_ADD   = int'(ST_ADD);
  localparam int IDX_SHIFT = int'(ST_SHIFT);

  logic [NUM_STATES-1:0] st_q;
  logic [NUM_STATES-1:0] st_d;
  logic [1:0]            idle_exits;  // [0] stay, [1] start
  logic [1:0]            shift_exits; // [0] next bit, [1] done
  logic [1:0]            lsb_exits;   // [1] add strobe
  logic                  lsb_skip;
  ctl_t                  ctl;

  // Decision in the waiting state on the start request
  ohc_demux2 u_dec_go (
    .en   (st_q[IDX_IDLE]),
    .sel  (go_i),
    .exits(idle_exits)
  );

  // Decision in the shift state on the counter zero flag
  ohc_demux2 u_dec_zero (
    .en   (st_q[IDX_SHIFT]),
    .sel  (cnt_zero_i),
    .exits(shift_exits)
  );

  // Conditional strobe in the add state on the multiplier bit
  ohc_demux2 u_dec_lsb (
    .en   (st_q[IDX_ADD]),
    .sel  (mplier_lsb_i),
    .exits(lsb_exits)
  );
  assign lsb_skip = lsb_exits[0];

  // Junctions into each state
  ohc_join #(.N(2)) u_join_idle (
    .paths ({shift_exits[1], idle_exits[0]}),
    .merged(st_d[IDX_IDLE])
  );

  ohc_join #(.N(2)) u_join_add (
    .paths ({shift_exits[0], idle_exits[1]}),
    .merged(st_d[IDX_ADD])
  );

  ohc_join #(.N(1)) u_join_shift (
    .paths (st_q[IDX_ADD]),
    .merged(st_d[IDX_SHIFT])
  );

  // Junction for the carry clear strobe
  ohc_join #(.N(2)) u_join_cclr (
    .paths ({st_q[IDX_SHIFT], idle_exits[1]}),
    .merged(ctl.carry_clr)
  );

  // One flip-flop per state; only the waiting state resets to 1
  for (genvar i = 0; i < NUM_STATES; i++) begin : g_state
    ohc_state_ff #(.RST_VAL((i == IDX_IDLE) ? 1'b1 : 1'b0)) u_ff (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (st_d[i]),
      .q    (st_q[i])
    );
  end

  always_comb begin
    ctl.init   = idle_exits[1];
    ctl.add_en = lsb_exits[1] & ~lsb_skip;
    ctl.shift  = st_q[IDX_SHIFT];
  end

  assign init_o      = ctl.init;
  assign add_en_o    = ctl.add_en;
  assign carry_clr_o = ctl.carry_clr;
  assign shift_o     = ctl.shift;
  assign st_idle_o   = st_q[IDX_IDLE];
  assign st_add_o    = st_q[IDX_ADD];
  assign st_shift_o  = st_q[IDX_SHIFT];
endmodule

// File: rtl/shiftadd_ctl_chk.sv
module shiftadd_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic go_i,
  input logic cnt_zero_i,
  input logic mplier_lsb_i,
  input logic init_o,
  input logic add_en_o,
  input logic carry_clr_o,
  input logic shift_o,
  input logic st_idle_o,
  input logic st_add_o,
  input logic st_shift_o
);
  a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_idle_o, st_add_o, st_shift_o}) == 1);

  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle_o && go_i) |=> st_add_o);

  a_r3_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle_o && !go_i) |=> st_idle_o);

  a_r4_add_then_shift: assert property (@(posedge clk) disable iff (!rst_n)
    st_add_o |=> st_shift_o);

  a_r5_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st_shift_o && cnt_zero_i) |=> st_idle_o);

  a_r5_next_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_shift_o && !cnt_zero_i) |=> st_add_o);

  a_r6_init_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |-> (st_idle_o && go_i));

  a_r7_add_in_add: assert property (@(posedge clk) disable iff (!rst_n)
    add_en_o |-> (st_add_o && mplier_lsb_i));

  a_r8_cclr_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (init_o || shift_o) |-> carry_clr_o);

  a_r9_shift_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    shift_o |=> !shift_o);
endmodule

bind shiftadd_onehot_ctl shiftadd_ctl_chk u_chk (.*);

// File: tb/sim_shiftadd_onehot_ctl.sv
module sim_shiftadd_onehot_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go_i = 1'b0, cnt_zero_i = 1'b0, mplier_lsb_i = 1'b0;
  logic init_o, add_en_o, carry_clr_o, shift_o;
  logic st_idle_o, st_add_o, st_shift_o;

  int checks = 0;
  int errors = 0;
  int ref_st = 0; // encoded reference: 0 wait, 1 add, 2 shift
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shiftadd_onehot_ctl u0 (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .cnt_zero_i(cnt_zero_i),
    .mplier_lsb_i(mplier_lsb_i), .init_o(init_o), .add_en_o(add_en_o),
    .carry_clr_o(carry_clr_o), .shift_o(shift_o), .st_idle_o(st_idle_o),
    .st_add_o(st_add_o), .st_shift_o(st_shift_o)
  );

  function automatic int ref_next(int s, logic g, logic z);
    case (s)
      0: return g ? 1 : 0;
      1: return 2;
      default: return z ? 0 : 1;
    endcase
  endfunction

  function automatic logic [2:0] ref_lines(int s);
    return {s == 2, s == 1, s == 0}; // {shift, add, wait}
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_all(string st_req);
    logic [2:0] lines;
    lines = {st_shift_o, st_add_o, st_idle_o};
    check("R2", 4'($countones(lines)), 4'd1);
    check(st_req, {1'b0, lines}, {1'b0, ref_lines(ref_st)});
    check("R6", {3'b0, init_o}, {3'b0, ref_st == 0 && go_i});
    check("R7", {3'b0, add_en_o}, {3'b0, ref_st == 1 && mplier_lsb_i});
    check("R8", {3'b0, carry_clr_o}, {3'b0, (ref_st == 0 && go_i) || ref_st == 2});
    check("R9", {3'b0, shift_o}, {3'b0, ref_st == 2});
  endtask

  // One cycle: drive at the falling edge, check, then advance the reference
  task automatic step(logic g, logic z, logic l, string st_req);
    @(negedge clk);
    go_i = g; cnt_zero_i = z; mplier_lsb_i = l;
    #1;
    check_all(st_req);
    @(posedge clk);
    ref_st = ref_next(ref_st, g, z);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; go_i = 1'b0; cnt_zero_i = 1'b1; mplier_lsb_i = 1'b1;
    #1;
    ref_st = 0;
    check("R1", {1'b0, st_shift_o, st_add_o, st_idle_o}, 4'b0001);
    check("R1", {init_o, add_en_o, carry_clr_o, shift_o}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    // R3 and R10: waiting state ignores the zero flag and the multiplier bit
    step(0, 1, 1, "R3");
    step(0, 0, 1, "R10");
    step(0, 1, 0, "R3");
    // start; R4 and R10: the add state ignores go_i and cnt_zero_i
    step(1, 1, 1, "R3");
    step(1, 1, 1, "R4");
    // shift without zero returns to add (R5)
    step(1, 0, 0, "R5");
    step(0, 1, 0, "R4");
    // shift with zero ends the run (R5)
    step(1, 1, 1, "R5");
    step(0, 0, 0, "R3");
    // start straight after done, then reset mid-run (R1)
    step(1, 0, 0, "R3");
    step(0, 0, 1, "R4");
    do_reset();
    step(0, 0, 0, "R1");
    // random sequences, checked against the encoded reference (R10 throughout)
    for (int i = 0; i < 3000; i++) begin
      logic g, z, l;
      g = ($urandom % 3) == 0;
      z = ($urandom % 4) == 0;
      l = $urandom % 2;
      step(g, z, l, ref_st == 0 ? "R3" : (ref_st == 1 ? "R4" : "R5"));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule